// File: doc/BRIEF.md
# Double-Buffered Serial Transmitter

This block sends words as asynchronous serial frames on a single line. It has two storage stages. A one-word holding buffer accepts writes from the surrounding logic. Behind it sits a shift register that builds and sends the frame. Whenever the shift register is free, a held word moves into it on the next clock. The holding buffer can then take the following word while the current frame is still on the line.

All bit timing comes from a one-cycle `tick` pulse at sixteen times the baud rate. A free-running divide-by-sixteen counter, cleared only by reset, splits these ticks into bit periods. A frame may begin only when that counter wraps.

Frame options are set by static inputs:
- a data length of eight or nine bits;
- an optional parity bit, even or odd;
- a stop length of half, one, one and a half or two bit times.

The ninth bit, when it is not parity, is sent as plain data, so it can act as a wake-up or address marker.

Top module: `dbuf_serial_tx`

## Requirements
- R1: After reset `txd` is 1, `bufEmpty` is 1, `txEmpty` is 1 and `overrun` is 0.
- R2: A frame starts only on a counter wrap, at tick numbers 16, 32, 48 and so on after reset. It starts only if `runEn` is 1 and a word is in the shift register. A word that is waiting while `runEn` is 0 starts at the first wrap after `runEn` rises.
- R3: A frame is a low start bit, then the data field LSB first, then high stop bits. Each start and data bit lasts exactly 16 ticks, and `txd` changes only in the cycle after a tick.
- R4: Without parity, the field is `wrData[7:0]` when `nineBit`=0 and `wrData[8:0]` when `nineBit`=1.
- R5: With `parityEn`=1, the field is `wrData[6:0]` followed by the parity bit when `nineBit`=0. It is `wrData[7:0]` followed by the parity bit when `nineBit`=1. Higher write bits are ignored. With `parityOdd`=0 the parity bit makes the count of ones in the field even; with `parityOdd`=1 it makes the count odd.
- R6: `stopSel` sets the stop length: 0 gives 8 ticks, 1 gives 16, 2 gives 24 and 3 gives 32. When a next word is ready, its start bit begins at the first counter wrap at or after the end of the stop time.
- R7: A write while the shift register is free drops `bufEmpty` for exactly one cycle. A write during a frame keeps `bufEmpty` low until the cycle after the first stop bit begins.
- R8: `txEmpty` rises in the same cycle that `txd` goes high for the first stop bit. It is 0 while a word waits in, or is being shifted out of, the shift register.
- R9: A write while the holding buffer is full replaces the held word, which is then never sent. It also sets `overrun`, which stays 1 until reset.
- R10: Clearing `runEn` during a frame does not cut the frame short.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rstN | input | 1 | Asynchronous reset, active low |
| tick | input | 1 | One-cycle pulse at 16x the baud rate |
| runEn | input | 1 | Allows new frames to start |
| nineBit | input | 1 | 1 selects a nine-bit data field, 0 selects eight |
| parityEn | input | 1 | 1 makes the last field bit a parity bit |
| parityOdd | input | 1 | 1 selects odd parity, 0 selects even |
| stopSel | input | 2 | Stop length: 0 half, 1 one, 2 one and a half, 3 two bit times |
| wrStrobe | input | 1 | Writes `wrData` into the holding buffer |
| wrData | input | DATA_W | Word to send |
| txd | output | 1 | Serial line, idles high |
| bufEmpty | output | 1 | Holding buffer can take a word |
| txEmpty | output | 1 | Shift register holds no unsent bits |
| overrun | output | 1 | Sticky flag: a held word was overwritten |

## Verification
If the divider is out of step, the start edge appears off a 16-tick boundary at the very first frame. If the bit counter is wrong, the frame gets longer or shorter, which shows in the stop position and in the next start time. If the stop counter is wrong, the gap between back-to-back frames changes, and that shows within one frame. If the buffer flags are wrong, the error shows one cycle after a write or after the first stop bit begins. An overrun mistake shows as the wrong word on the line in the following frame.

// File: rtl/dbtx_pkg.sv
package dbtx_pkg;

  typedef enum logic [1:0] {
    ST_IDLE,
    ST_START,
    ST_DATA,
    ST_STOP
  } txState_e;

  // One-cycle strobes from control to datapath; at most one is high.
  typedef struct packed {
    logic startFrame;  // drive the start bit
    logic shiftBit;    // put the next field bit on the line
    logic enterStop;   // drive stop level and free the shifter
  } txStrobe_t;

endpackage

// File: rtl/dbtx_ctrl.sv
module dbtx_ctrl
  import dbtx_pkg::*;
#(
  parameter int TICKS_PER_BIT = 16,
  parameter int MAX_BITS      = 9
) (
  input  logic       clk,
  input  logic       rstN,
  input  logic       tick,
  input  logic       runEn,
  input  logic       nineBit,
  input  logic [1:0] stopSel,
  input  logic       shiftLoaded,
  output txStrobe_t  strobes
);

  localparam int DIV_W    = $clog2(TICKS_PER_BIT);
  localparam int HALF_BIT = TICKS_PER_BIT / 2;
  localparam int STOP_W   = $clog2(2 * TICKS_PER_BIT + 1);
  localparam int BIT_W    = $clog2(MAX_BITS + 1);

  txState_e          state, stateNext;
  logic [DIV_W-1:0]  divCnt;
  logic [BIT_W-1:0]  bitCnt, bitCntNext, lastIdx;
  logic [STOP_W-1:0] stopCnt, stopCntNext, stopLen;
  logic              bitEdge, canStart, stopDone;

  // Divider wrap: the only moments a bit period may begin.
  assign bitEdge  = tick && (divCnt == DIV_W'(TICKS_PER_BIT - 1));
  assign canStart = runEn && shiftLoaded;
  assign lastIdx  = nineBit ? BIT_W'(MAX_BITS - 1) : BIT_W'(MAX_BITS - 2);
  assign stopLen  = STOP_W'(HALF_BIT * (int'(stopSel) + 1));
  assign stopDone = tick && (stopCnt == stopLen - STOP_W'(1));

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      divCnt  <= '0;
      state   <= ST_IDLE;
      bitCnt  <= '0;
      stopCnt <= '0;
    end else begin
      if (tick) divCnt <= bitEdge ? '0 : divCnt + DIV_W'(1);
      state   <= stateNext;
      bitCnt  <= bitCntNext;
      stopCnt <= stopCntNext;
    end
  end

  always_comb begin
    stateNext   = state;
    bitCntNext  = bitCnt;
    stopCntNext = stopCnt;
    strobes     = '0;
    unique case (state)
      ST_IDLE: begin
        if (bitEdge && canStart) begin
          stateNext          = ST_START;
          strobes.startFrame = 1'b1;
        end
      end
      ST_START: begin
        if (bitEdge) begin
          stateNext        = ST_DATA;
          bitCntNext       = '0;
          strobes.shiftBit = 1'b1;
        end
      end
      ST_DATA: begin
        if (bitEdge) begin
          if (bitCnt == lastIdx) begin
            stateNext         = ST_STOP;
            stopCntNext       = '0;
            strobes.enterStop = 1'b1;
          end else begin
            bitCntNext       = bitCnt + BIT_W'(1);
            strobes.shiftBit = 1'b1;
          end
        end
      end
      ST_STOP: begin
        if (tick) begin
          stopCntNext = stopCnt + STOP_W'(1);
          if (stopDone) begin
            // Whole stop lengths end on a wrap, so the next frame can follow directly.
            if (bitEdge && canStart) begin
              stateNext          = ST_START;
              strobes.startFrame = 1'b1;
            end else begin
              stateNext = ST_IDLE;
            end
          end
        end
      end
      default: stateNext = ST_IDLE;
    endcase
  end

endmodule

// File: rtl/dbtx_datapath.sv
module dbtx_datapath
  import dbtx_pkg::*;
#(
  parameter int DATA_W = 9
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              wrStrobe,
  input  logic [DATA_W-1:0] wrData,
  input  logic              nineBit,
  input  logic              parityEn,
  input  logic              parityOdd,
  input  txStrobe_t         strobes,
  output logic              shiftLoaded,
  output logic              txd,
  output logic              bufEmpty,
  output logic              txEmpty,
  output logic              overrun
);

  logic [DATA_W-1:0] holdReg, shiftReg, field;
  logic              holdFull, moveNow, parBit;

  assign moveNow = holdFull && !shiftLoaded;

  // Build the field from the held word as it moves into the shifter.
  always_comb begin
    parBit = 1'b0;
    field  = holdReg;
    if (parityEn) begin
      if (nineBit) begin
        parBit = (^holdReg[DATA_W-2:0]) ^ parityOdd;
        field  = {parBit, holdReg[DATA_W-2:0]};
      end else begin
        parBit = (^holdReg[DATA_W-3:0]) ^ parityOdd;
        field  = {1'b0, parBit, holdReg[DATA_W-3:0]};
      end
    end else if (!nineBit) begin
      field = {1'b0, holdReg[DATA_W-2:0]};
    end
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      holdReg  <= '0;
      holdFull <= 1'b0;
      overrun  <= 1'b0;
    end else if (wrStrobe) begin
      holdReg  <= wrData;
      holdFull <= 1'b1;
      if (holdFull && !moveNow) overrun <= 1'b1;
    end else if (moveNow) begin
      holdFull <= 1'b0;
    end
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      shiftReg    <= '0;
      shiftLoaded <= 1'b0;
      txd         <= 1'b1;
    end else begin
      if (moveNow) begin
        shiftReg    <= field;
        shiftLoaded <= 1'b1;
      end else if (strobes.shiftBit) begin
        shiftReg <= shiftReg >> 1;
      end
      if (strobes.enterStop) shiftLoaded <= 1'b0;
      if (strobes.startFrame)     txd <= 1'b0;
      else if (strobes.shiftBit)  txd <= shiftReg[0];
      else if (strobes.enterStop) txd <= 1'b1;
    end
  end

  assign bufEmpty = !holdFull;
  assign txEmpty  = !shiftLoaded;

endmodule

// File: rtl/dbuf_serial_tx.sv
module dbuf_serial_tx
  import dbtx_pkg::*;
#(
  parameter int DATA_W        = 9,
  parameter int TICKS_PER_BIT = 16
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              tick,
  input  logic              runEn,
  input  logic              nineBit,
  input  logic              parityEn,
  input  logic              parityOdd,
  input  logic [1:0]        stopSel,
  input  logic              wrStrobe,
  input  logic [DATA_W-1:0] wrData,
  output logic              txd,
  output logic              bufEmpty,
  output logic              txEmpty,
  output logic              overrun
);

  txStrobe_t strobes;
  logic      shiftLoaded;

  dbtx_ctrl #(
    .TICKS_PER_BIT(TICKS_PER_BIT),
    .MAX_BITS     (DATA_W)
  ) u_ctrl (
    .clk        (clk),
    .rstN       (rstN),
    .tick       (tick),
    .runEn      (runEn),
    .nineBit    (nineBit),
    .stopSel    (stopSel),
    .shiftLoaded(shiftLoaded),
    .strobes    (strobes)
  );

  dbtx_datapath #(
    .DATA_W(DATA_W)
  ) u_datapath (
    .clk        (clk),
    .rstN       (rstN),
    .wrStrobe   (wrStrobe),
    .wrData     (wrData),
    .nineBit    (nineBit),
    .parityEn   (parityEn),
    .parityOdd  (parityOdd),
    .strobes    (strobes),
    .shiftLoaded(shiftLoaded),
    .txd        (txd),
    .bufEmpty   (bufEmpty),
    .txEmpty    (txEmpty),
    .overrun    (overrun)
  );

endmodule

// File: rtl/dbtx_checker.sv
module dbtx_checker
  import dbtx_pkg::*;
#(
  parameter int TICKS_PER_BIT = 16
) (
  input logic      clk,
  input logic      rstN,
  input logic      tick,
  input logic      wrStrobe,
  input logic      txd,
  input logic      bufEmpty,
  input logic      txEmpty,
  input logic      overrun,
  input txStrobe_t strobes
);

  localparam int CW = $clog2(TICKS_PER_BIT);

  // Independent tick count used to locate period boundaries.
  logic [CW-1:0] chkCnt;
  logic          chkWrap;
  assign chkWrap = tick && (chkCnt == CW'(TICKS_PER_BIT - 1));

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN)     chkCnt <= '0;
    else if (tick) chkCnt <= chkCnt + CW'(1);
  end

  a_r1_r8_line_high_when_free: assert property (@(posedge clk) disable iff (!rstN)
    txEmpty |-> txd);

  a_r2_start_on_wrap: assert property (@(posedge clk) disable iff (!rstN)
    $fell(txd) |-> $past(chkWrap));

  a_r3_line_moves_on_tick: assert property (@(posedge clk) disable iff (!rstN)
    !$stable(txd) |-> $past(tick));

  a_r3_strobes_exclusive: assert property (@(posedge clk) disable iff (!rstN)
    $onehot0(strobes));

  a_r7_fill_needs_write: assert property (@(posedge clk) disable iff (!rstN)
    $fell(bufEmpty) |-> $past(wrStrobe));

  a_r9_overrun_cause: assert property (@(posedge clk) disable iff (!rstN)
    $rose(overrun) |-> $past(wrStrobe && !bufEmpty));

  a_r9_overrun_sticky: assert property (@(posedge clk) disable iff (!rstN)
    overrun |=> overrun);

endmodule

bind dbuf_serial_tx dbtx_checker #(.TICKS_PER_BIT(TICKS_PER_BIT)) u_checker (
  .clk     (clk),
  .rstN    (rstN),
  .tick    (tick),
  .wrStrobe(wrStrobe),
  .txd     (txd),
  .bufEmpty(bufEmpty),
  .txEmpty (txEmpty),
  .overrun (overrun),
  .strobes (strobes)
);

// File: tb/dbuf_serial_tx_bench.sv
`timescale 1ns/1ps
module dbuf_serial_tx_bench;

  logic       clk = 1'b0;
  logic       rstN = 1'b0;
  logic       tick = 1'b0;
  logic       runEn = 1'b1;
  logic       nineBit = 1'b0;
  logic       parityEn = 1'b0;
  logic       parityOdd = 1'b0;
  logic [1:0] stopSel = 2'd1;
  logic       wrStrobe = 1'b0;
  logic [8:0] wrData = '0;
  logic       txd, bufEmpty, txEmpty, overrun;

  int checks = 0;
  int errors = 0;
  int tickNum = 0;

  always #2 clk = ~clk;

  dbuf_serial_tx u_dbuf_serial_tx (
    .clk(clk), .rstN(rstN), .tick(tick), .runEn(runEn), .nineBit(nineBit),
    .parityEn(parityEn), .parityOdd(parityOdd), .stopSel(stopSel),
    .wrStrobe(wrStrobe), .wrData(wrData), .txd(txd), .bufEmpty(bufEmpty),
    .txEmpty(txEmpty), .overrun(overrun)
  );

  initial begin
    forever begin
      @(negedge clk);
      tick = rstN ? ~tick : 1'b0;
    end
  end

  always @(posedge clk) begin
    if (!rstN) tickNum <= 0;
    else if (tick) tickNum <= tickNum + 1;
  end

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual %0h expected %0h", req, act, exp);
    end
  endtask

  function automatic logic [8:0] expField(input logic [8:0] d, input logic nine,
                                          input logic par, input logic odd);
    logic [8:0] f;
    if (!par) f = nine ? d : {1'b0, d[7:0]};
    else if (nine) f = {(^d[7:0]) ^ odd, d[7:0]};
    else f = {1'b0, (^d[6:0]) ^ odd, d[6:0]};
    return f;
  endfunction

  task automatic waitTick(input int target);
    while (tickNum < target) @(negedge clk);
  endtask

  task automatic writeWord(input logic [8:0] d);
    @(negedge clk);
    wrStrobe = 1'b1;
    wrData   = d;
    @(negedge clk);
    wrStrobe = 1'b0;
  endtask

  task automatic setCfg(input logic nine, input logic par, input logic odd, input logic [1:0] sel);
    nineBit = nine; parityEn = par; parityOdd = odd; stopSel = sel;
  endtask

  task automatic captureFrame(input int n, output logic [8:0] bits, output int startTick);
    bits = '0;
    @(negedge clk);
    while (txd !== 1'b0) @(negedge clk);
    startTick = tickNum;
    check("R2 start on 16-tick boundary", startTick % 16, 0);
    waitTick(startTick + 8);
    check("R3 start bit low", txd, 0);
    for (int i = 0; i < n; i++) begin
      waitTick(startTick + 16 * (i + 1) + 8);
      bits[i] = txd;
      if (i == n - 1) check("R8 txEmpty low during last data bit", txEmpty, 0);
    end
    waitTick(startTick + 16 * (n + 1));
    check("R8 txEmpty rises with first stop bit", txEmpty, 1);
    check("R3 stop bit high", txd, 1);
    waitTick(startTick + 16 * (n + 1) + 4);
    check("R3 stop bit still high", txd, 1);
  endtask

  task automatic testReset();
    check("R1 txd after reset", txd, 1);
    check("R1 bufEmpty after reset", bufEmpty, 1);
    check("R1 txEmpty after reset", txEmpty, 1);
    check("R1 overrun after reset", overrun, 0);
  endtask

  task automatic testFrame(input logic nine, input logic par, input logic odd,
                           input logic [8:0] d, input string tag);
    logic [8:0] bits;
    int st;
    setCfg(nine, par, odd, 2'd1);
    writeWord(d);
    check("R7 bufEmpty low one cycle after idle write", bufEmpty, 0);
    @(negedge clk);
    check("R7 bufEmpty back high after move", bufEmpty, 1);
    check("R8 txEmpty low while word waits", txEmpty, 0);
    captureFrame(nine ? 9 : 8, bits, st);
    check(tag, bits, expField(d, nine, par, odd));
    waitTick(tickNum + 32);
  endtask

  task automatic testStopGap(input logic [1:0] sel);
    logic [8:0] b1, b2;
    int s1, s2, stopT;
    setCfg(1'b0, 1'b0, 1'b0, sel);
    stopT = 8 * (int'(sel) + 1);
    writeWord(9'h0C3);
    @(negedge clk);
    writeWord(9'h05A);
    check("R7 bufEmpty low while second word held", bufEmpty, 0);
    captureFrame(8, b1, s1);
    check("R7 bufEmpty high after first stop begins", bufEmpty, 1);
    captureFrame(8, b2, s2);
    check("R6 first word", b1, 9'h0C3);
    check("R6 second word", b2, 9'h05A);
    check("R6 gap for stop select", s2 - s1, 16 * 9 + ((stopT + 15) / 16) * 16);
    waitTick(tickNum + 48);
  endtask

  task automatic testRun();
    logic [8:0] bits;
    int st, t, expStart;
    setCfg(1'b0, 1'b0, 1'b0, 2'd1);
    runEn = 1'b0;
    writeWord(9'h03C);
    waitTick(tickNum + 40);
    check("R2 no start while runEn low", txd, 1);
    check("R2 word waits in shifter", txEmpty, 0);
    @(negedge clk);
    runEn = 1'b1;
    t = tickNum;
    expStart = (t / 16 + 1) * 16;
    captureFrame(8, bits, st);
    check("R2 start at first wrap after runEn", st, expStart);
    check("R2 word after hold-off", bits, 9'h03C);
    waitTick(tickNum + 32);
    writeWord(9'h10F);
    fork
      captureFrame(8, bits, st);
      begin
        while (txd !== 1'b0) @(negedge clk);
        waitTick(tickNum + 40);
        runEn = 1'b0;
      end
    join
    check("R10 frame completes after runEn cleared", bits, 9'h00F);
    runEn = 1'b1;
    waitTick(tickNum + 32);
  endtask

  task automatic testOverrun();
    logic [8:0] b1, b2;
    int s1, s2;
    setCfg(1'b0, 1'b0, 1'b0, 2'd1);
    runEn = 1'b0;
    writeWord(9'h011);
    @(negedge clk);
    writeWord(9'h022);
    check("R9 no overrun on first held word", overrun, 0);
    writeWord(9'h033);
    check("R9 overrun set by write to full buffer", overrun, 1);
    check("R9 buffer still full", bufEmpty, 0);
    runEn = 1'b1;
    captureFrame(8, b1, s1);
    captureFrame(8, b2, s2);
    check("R9 shifter word sent", b1, 9'h011);
    check("R9 overwriting word sent, replaced one dropped", b2, 9'h033);
    waitTick(tickNum + 48);
    check("R9 overrun sticky", overrun, 1);
    check("R9 nothing further pending", bufEmpty & txEmpty & txd, 1);
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    checks++;
    errors++;
    $display("FAIL watchdog: actual hung expected done");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    repeat (4) @(negedge clk);
    rstN = 1'b1;
    @(negedge clk);
    testReset();
    testFrame(1'b0, 1'b0, 1'b0, 9'h0A5, "R4 eight-bit field");
    testFrame(1'b1, 1'b0, 1'b0, 9'h13C, "R4 nine-bit field with ninth bit");
    testFrame(1'b0, 1'b1, 1'b0, 9'h053, "R5 seven bits plus even parity");
    testFrame(1'b1, 1'b1, 1'b1, 9'h0F1, "R5 eight bits plus odd parity");
    testFrame(1'b0, 1'b1, 1'b1, 9'h1FF, "R5 upper bits ignored, odd parity");
    for (int s = 0; s < 4; s++) testStopGap(2'(s));
    testRun();
    testOverrun();
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

endmodule